// File: doc/BRIEF.md
# Segmented Grey-Scale Pulse Driver

This block turns a grey-scale code into an on/off enable for one LED channel or for a small bank of channels. It does not produce one long pulse per display period. It splits the period into many short segments and gives each segment a short pulse. Each code is cut into two fields. The upper field sets the pulse width inside every segment. The lower field says how many segments get one extra count. Because of this, the visible refresh rate is the segment count times the period rate, and the grey-scale clock does not need to run any faster.

The block's own clock is the grey-scale clock: one cycle is one grey-scale count. A segment has an active window of `2^UPPER_W` counts followed by `BLANK_CYC` dead counts. In the dead counts the output is always off, so an outside row scanner can switch rows. The scanner advances on the one-cycle segment strobe.

Codes are written one channel at a time into a holding register. The pulse logic only uses a code after the next period boundary. The boundary comes either from the period-start strobe or from the end of the last segment. The lower field must be at least two bits wide.

Top module: `spwm_pixel_driver`

## Requirements
- R1: After reset every `chan_on` bit and `seg_strobe` stay low until the first `period_start` is sampled.
- R2: In a code word, the upper field is bits `[UPPER_W+LOWER_W-1:LOWER_W]` and the lower field is bits `[LOWER_W-1:0]`.
- R3: The cycle after `period_start` is sampled high is index 0 of a period. The period has `2^LOWER_W` segments of `2^UPPER_W+BLANK_CYC` cycles each. `seg_strobe` is high in exactly the first cycle of every segment.
- R4: In segment s, a channel is high for the first w cycles and low for the rest. Here w is the upper field plus one when s is less than the lower field, and the upper field alone otherwise.
- R5: The number of high cycles of a channel over one period equals upper·2^LOWER_W + lower. A zero code keeps the channel low for the whole period.
- R6: The last `BLANK_CYC` cycles of every segment are low on every channel.
- R7: A written code goes into a holding register. It becomes active only at the next period boundary. When a write and `period_start` are sampled on the same edge, the new period uses the code held before that write.
- R8: After the last cycle of the last segment, a new period starts at once without a strobe, using the holding register.
- R9: A `period_start` sampled in the middle of a period makes the next cycle index 0 of a fresh period.
- R10: A write changes only the channel chosen by `code_wr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grey-scale clock, one cycle per count |
| rst_n | input | 1 | Synchronous active-low reset |
| period_start | input | 1 | Starts a fresh period on the next cycle |
| code_wr_en | input | 1 | Writes `code_wr_data` into the holding register of the chosen channel |
| code_wr_sel | input | max(1, clog2(CHANNELS)) | Channel index for the write |
| code_wr_data | input | UPPER_W+LOWER_W | Grey-scale code |
| chan_on | output | CHANNELS | Per-channel LED enable |
| seg_strobe | output | 1 | High for one cycle at the start of each segment |

## Verification
Two events can fall on the same edge: a code write into the holding register and a period boundary. The boundary can be an external restart strobe or the automatic wrap after the last segment. The bench raises a write and `period_start` together in the middle of a period. It then checks every cycle of the restarted period against the old code, and every cycle of the following wrapped period against the new code. A second case writes in the middle of a period with no strobe. There, the rest of the current period must keep the old pattern and the new code must appear exactly at the wrap.

// File: rtl/spwm_pkg.sv
// Package: shared sizing helpers for the segmented pulse driver.
// Assumes UPPER_W >= 1 and BLANK_CYC >= 0.
package spwm_pkg;

    // Number of grey-scale counts in one segment (active window plus dead time).
    function automatic int seg_len(input int upper_w, input int blank_cyc);
        return (1 << upper_w) + blank_cyc;
    endfunction

    // Width of a counter that can hold every segment position and the value seg_len.
    function automatic int pos_width(input int upper_w, input int blank_cyc);
        return $clog2(seg_len(upper_w, blank_cyc) + 1);
    endfunction

endpackage

// File: rtl/spwm_timebase.sv
// Module: spwm_timebase
// Tracks the position inside a segment and the segment index inside a period.
// Produces the segment strobe, the end-of-segment flag and the period boundary
// pulse. The boundary is either an external restart or the wrap after the last
// segment. Assumes LOWER_W >= 2 and clk is the grey-scale clock.
module spwm_timebase #(
    parameter int UPPER_W   = 9,
    parameter int LOWER_W   = 7,
    parameter int BLANK_CYC = 2,
    parameter int POS_W     = spwm_pkg::pos_width(UPPER_W, BLANK_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_start,
    output logic             running,
    output logic [POS_W-1:0] pos,
    output logic             seg_end,
    output logic             period_load,
    output logic             seg_strobe
);
    localparam int SEG_LEN = spwm_pkg::seg_len(UPPER_W, BLANK_CYC);

    logic               running_q;
    logic [POS_W-1:0]   pos_q;
    logic [LOWER_W-1:0] seg_q;

    // Decode segment and period boundaries from the counters.
    always_comb begin
        seg_end     = running_q && (pos_q == POS_W'(SEG_LEN - 1));
        period_load = period_start || (seg_end && (&seg_q));
        seg_strobe  = running_q && (pos_q == '0);
        running     = running_q;
        pos         = pos_q;
    end

    // Advance position and segment counters; a restart strobe clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            pos_q     <= '0;
            seg_q     <= '0;
        end else if (period_start) begin
            running_q <= 1'b1;
            pos_q     <= '0;
            seg_q     <= '0;
        end else if (running_q) begin
            if (seg_end) begin
                pos_q <= '0;
                seg_q <= seg_q + 1'b1;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q < POS_W'(SEG_LEN)); // R3
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        seg_strobe |=> !seg_strobe); // R3
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> (running_q && pos_q == '0 && seg_q == '0)); // R9
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_end && (&seg_q)) |=> (seg_q == '0 && pos_q == '0)); // R8

endmodule

// File: rtl/spwm_channel.sv
// Module: spwm_channel
// One LED channel. Holds a code in a holding register and an active copy of it.
// The active copy is loaded at each period boundary. A remainder counter starts
// at the lower field and drops by one at every segment end. Each segment's
// pulse is the upper field, plus one while the remainder is non-zero.
// Assumes the timebase guarantees that pos never reaches SEG_LEN.
module spwm_channel #(
    parameter int UPPER_W = 9,
    parameter int LOWER_W = 7,
    parameter int POS_W   = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [UPPER_W+LOWER_W-1:0] wr_code,
    input  logic                       period_load,
    input  logic                       seg_end,
    input  logic                       running,
    input  logic [POS_W-1:0]           pos,
    output logic                       on
);
    localparam int CODE_W = UPPER_W + LOWER_W;

    logic [CODE_W-1:0]  shadow_q;
    logic [UPPER_W-1:0] upper_q;
    logic [LOWER_W-1:0] rem_q;
    logic               extra;
    logic [POS_W-1:0]   width;

    // Holding register: takes every write addressed to this channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr_en) begin
            shadow_q <= wr_code;
        end
    end

    // Active code: reload at a period boundary; otherwise spend the remainder segment by segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            rem_q   <= '0;
        end else if (period_load) begin
            upper_q <= shadow_q[CODE_W-1:LOWER_W];
            rem_q   <= shadow_q[LOWER_W-1:0];
        end else if (seg_end && (rem_q != '0)) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    // Pulse width of this segment, and the channel enable from the segment position.
    always_comb begin
        extra = (rem_q != '0);
        width = POS_W'(upper_q) + POS_W'(extra);
        on    = running && (pos < width);
    end

    AST_DARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !on); // R1
    AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= POS_W'(1 << UPPER_W)) |-> !on); // R6
    AST_REM_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !period_load |=> (rem_q <= $past(rem_q))); // R4
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_load |=> $stable(upper_q)); // R7

endmodule

// File: rtl/spwm_pixel_driver.sv
// Module: spwm_pixel_driver (top)
// Segmented grey-scale pulse driver for a bank of LED channels. One shared
// timebase drives CHANNELS copies of the channel logic. Writes are steered to
// a single channel by index. Assumes LOWER_W >= 2 and that clk is the
// grey-scale clock.
module spwm_pixel_driver #(
    parameter int UPPER_W   = 9,
    parameter int LOWER_W   = 7,
    parameter int BLANK_CYC = 2,
    parameter int CHANNELS  = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          period_start,
    input  logic                                          code_wr_en,
    input  logic [$clog2(CHANNELS > 1 ? CHANNELS : 2)-1:0] code_wr_sel,
    input  logic [UPPER_W+LOWER_W-1:0]                    code_wr_data,
    output logic [CHANNELS-1:0]                           chan_on,
    output logic                                          seg_strobe
);
    localparam int SEL_W = $clog2(CHANNELS > 1 ? CHANNELS : 2);
    localparam int POS_W = spwm_pkg::pos_width(UPPER_W, BLANK_CYC);

    logic             running;
    logic [POS_W-1:0] pos;
    logic             seg_end;
    logic             period_load;

    spwm_timebase #(
        .UPPER_W  (UPPER_W),
        .LOWER_W  (LOWER_W),
        .BLANK_CYC(BLANK_CYC),
        .POS_W    (POS_W)
    ) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_start(period_start),
        .running     (running),
        .pos         (pos),
        .seg_end     (seg_end),
        .period_load (period_load),
        .seg_strobe  (seg_strobe)
    );

    // One channel instance per output, each with its own write select.
    for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
        logic wr_hit;

        // Steer the write to this channel when the index matches.
        always_comb wr_hit = code_wr_en && (code_wr_sel == SEL_W'(i));

        spwm_channel #(
            .UPPER_W(UPPER_W),
            .LOWER_W(LOWER_W),
            .POS_W  (POS_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_hit),
            .wr_code    (code_wr_data),
            .period_load(period_load),
            .seg_end    (seg_end),
            .running    (running),
            .pos        (pos),
            .on         (chan_on[i])
        );
    end

    AST_START_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> seg_strobe); // R3
    AST_STROBE_DARK_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!seg_strobe && chan_on == '0)); // R1

endmodule

// File: tb/tb_spwm_pixel_driver.sv
// Bench: sweeps every 5-bit code (3 upper, 2 lower bits, 1 dead cycle) on two
// channels, then drives the write/boundary collisions. Expected outputs are
// computed per cycle from the requirements.
module tb_spwm_pixel_driver;
    localparam int U      = 3;
    localparam int L      = 2;
    localparam int BL     = 1;
    localparam int N      = 2;
    localparam int CW     = U + L;
    localparam int SEGLEN = (1 << U) + BL;
    localparam int PER    = SEGLEN * (1 << L);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          period_start = 1'b0;
    logic          wr_en = 1'b0;
    logic [0:0]    wr_sel = '0;
    logic [CW-1:0] wr_data = '0;
    logic [N-1:0]  chan_on;
    logic          seg_strobe;

    int errors = 0;
    int checks = 0;
    int sum0 = 0;
    int sum1 = 0;
    bit done = 1'b0;

    spwm_pixel_driver #(
        .UPPER_W(U), .LOWER_W(L), .BLANK_CYC(BL), .CHANNELS(N)
    ) dut (
        .clk(clk), .rst_n(rst_n), .period_start(period_start),
        .code_wr_en(wr_en), .code_wr_sel(wr_sel), .code_wr_data(wr_data),
        .chan_on(chan_on), .seg_strobe(seg_strobe)
    );

    always #4 clk = ~clk;

    // Expected enable at period index k (R2 field split, R4 widths, R6 dead cycle).
    function automatic bit exp_on(input int code, input int k);
        int seg = k / SEGLEN;
        int p   = k % SEGLEN;
        int up  = code >> L;
        int lo  = code & ((1 << L) - 1);
        int w   = up + ((seg < lo) ? 1 : 0);
        return (p < w);
    endfunction

    // Check indices k0..k1 at successive falling edges; leaves time at index k1+1.
    task automatic check_span(input int c0, input int c1, input int k0, input int k1, input string tag);
        for (int k = k0; k <= k1; k++) begin
            bit e0 = exp_on(c0, k);
            bit e1 = exp_on(c1, k);
            bit es = ((k % SEGLEN) == 0);
            checks++;
            if (chan_on[0]) sum0++;
            if (chan_on[1]) sum1++;
            if (chan_on !== {e1, e0} || seg_strobe !== es) begin
                errors++;
                $display("FAIL %s idx %0d: on=%b strobe=%b expected on=%b strobe=%b",
                         tag, k, chan_on, seg_strobe, {e1, e0}, es);
            end
            @(negedge clk);
        end
    endtask

    task automatic write_code(input int sel, input int code);
        wr_en   = 1'b1;
        wr_sel  = sel[0:0];
        wr_data = code[CW-1:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic begin_period();
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
    endtask

    task automatic check_sum(input int got, input int code, input string tag);
        checks++;
        if (got != code) begin
            errors++;
            $display("FAIL %s on-count: got %0d expected %0d", tag, got, code);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: dark and no strobe before any period start
        for (int i = 0; i < 6; i++) begin
            checks++;
            if (chan_on !== '0 || seg_strobe !== 1'b0) begin
                errors++;
                $display("FAIL R1 idle: on=%b strobe=%b expected on=00 strobe=0", chan_on, seg_strobe);
            end
            @(negedge clk);
        end
        // Full sweep: R2 R3 R4 R6 per cycle, R5 per period (code 0 included)
        for (int c = 0; c < (1 << CW); c++) begin
            write_code(0, c);
            write_code(1, (1 << CW) - 1 - c);
            begin_period();
            sum0 = 0;
            sum1 = 0;
            check_span(c, (1 << CW) - 1 - c, 0, PER - 1, "R2 R3 R4 R6");
            check_sum(sum0, c, "R5 ch0");
            check_sum(sum1, (1 << CW) - 1 - c, "R5 ch1");
        end
        // R7: mid-period write must not disturb the running period; R8: appears at the wrap
        write_code(0, 5);
        write_code(1, 22);
        begin_period();
        check_span(5, 22, 0, 9, "R7");
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = CW'(27);
        check_span(5, 22, 10, 10, "R7");
        wr_en = 1'b0;
        check_span(5, 22, 11, PER - 1, "R7");
        check_span(27, 22, 0, PER - 1, "R8");
        // R9 restart mid-period together with a write (R7 collision)
        check_span(27, 22, 0, 6, "R8");
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = CW'(9); period_start = 1'b1;
        check_span(27, 22, 7, 7, "R9");
        wr_en = 1'b0; period_start = 1'b0;
        check_span(27, 22, 0, PER - 1, "R7 R9");
        check_span(27, 9, 0, PER - 1, "R7 R8");
        // R10: write channel 0 only; channel 1 keeps its code
        write_code(0, 14);
        begin_period();
        check_span(14, 9, 0, PER - 1, "R10");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule